// File: doc/BRIEF.md
# Data Cache Maintenance Operation Controller

This block carries out local maintenance operations on a small direct-mapped data cache. It has four kinds of operation: touch, touch-for-store, invalidate and ordering barrier. They arrive on an operation port together with an address that has already been translated. It also serves ordinary demand loads on a second port. All misses are refilled through a single line-fill bus master that uses a request/acknowledge/error handshake. No operation is ever sent to other bus agents. The only bus traffic the block makes is the fill that a miss needs.

A touch is an ordinary fill with one difference: it swallows bus errors. A demand load that sees the same error reports it on `ld_err`. Only fills that complete without error install a line. The block handles one request at a time. A four-state machine (IDLE, LOOKUP, FILL, DONE) runs every request. IDLE moves to LOOKUP when a request is accepted. LOOKUP moves to DONE on a hit, on an invalidate or on a barrier, and it moves to FILL on a touch miss or a load miss. FILL stays in FILL while beats remain and moves to DONE on the last clean beat or on an errored beat. DONE always returns to IDLE.

Top module: `dcache_maint_ctrl`

## Requirements
- R1: After reset, `op_busy`, `op_done`, `ld_done` and `fill_req` are low and every cache line is invalid. A reset that arrives later also invalidates every line.
- R2: Operation codes on `op_code` are 3'b001 touch, 3'b010 touch-for-store and 3'b011 invalidate. 3'b100 is the barrier. A request with 3'b000, or with any code from 3'b101 to 3'b111, is not accepted and leaves `op_busy` low.
- R3: A touch or touch-for-store that hits finishes with `op_done` two cycles after acceptance and produces no fill beat.
- R4: A touch, touch-for-store or load that misses holds `fill_req` high with a stable `fill_addr` until each beat is acknowledged. The fill runs four 32-bit beats at word addresses line_base+0, +4, +8 and +12, and completes six cycles after acceptance.
- R5: A bus error on a fill that a touch started ends the fill at that beat, so an error on beat k (counting from 0) gives done 3+k cycles after acceptance. `ld_err` stays low, and the line is left invalid.
- R6: A fill with no error installs the line, so the next access to the same line hits.
- R7: An invalidate that hits clears that line. An invalidate that misses changes nothing. Either way it finishes two cycles after acceptance with no bus beat.
- R8: A barrier finishes two cycles after acceptance. It is issued only while no bus access is outstanding, and it produces no bus beat.
- R9: A load that hits returns the addressed word on `ld_data` with `ld_done` two cycles after acceptance. A load whose fill takes a bus error asserts `ld_err` together with `ld_done`.
- R10: `op_busy` is high from the cycle after acceptance up to and including the completion cycle. `op_done` and `ld_done` are single-cycle pulses.
- R11: The cache is direct-mapped with 16 lines of 16 bytes. Address bits [7:4] select the line and bits [31:8] form the tag, so two addresses with the same index replace each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Maintenance operation request |
| op_code | input | 3 | Operation code |
| op_addr | input | 32 | Translated operation address |
| op_busy | output | 1 | Controller occupied |
| op_done | output | 1 | Maintenance operation completed (pulse) |
| ld_valid | input | 1 | Demand load request |
| ld_addr | input | 32 | Load address |
| ld_done | output | 1 | Load completed (pulse) |
| ld_data | output | 32 | Loaded word |
| ld_err | output | 1 | Load bus-error interrupt (pulse with ld_done) |
| fill_req | output | 1 | Fill beat request |
| fill_addr | output | 32 | Word address of the current beat |
| fill_ack | input | 1 | Beat acknowledge |
| fill_err | input | 1 | Beat error, valid with fill_ack |
| fill_data | input | 32 | Beat data |

## Verification
Every result is timed from the clock edge that accepts the request. A hit, an invalidate or a barrier completes after 2 cycles. A full fill, with the bus acknowledging every cycle, completes after 6 cycles. A fill that an error cuts short at beat k completes after 3+k cycles. The bench issues each request at a falling edge and then counts falling edges until a done pulse appears. It compares that count, the number of acknowledged beats, `ld_err` and `ld_data` with the values in its table. One falling edge later it confirms that the pulse has dropped and that busy is low.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_TOUCH    = 3'd1,
        OP_TOUCH_ST = 3'd2,
        OP_INVAL    = 3'd3,
        OP_BARRIER  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOOKUP,
        S_FILL,
        S_DONE
    } state_e;

    typedef enum logic [1:0] {
        K_TOUCH,
        K_INVAL,
        K_BARRIER,
        K_LOAD
    } kind_e;
endpackage

// File: rtl/dcm_tag_store.sv
module dcm_tag_store #(
    parameter int LINES = 16,
    parameter int TAG_W = 24,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0] set_tag
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
            end else if (set_en && set_idx == IDX_W'(g)) begin
                valid_q[g] <= 1'b1;
            end else if (clr_en && clr_idx == IDX_W'(g)) begin
                valid_q[g] <= 1'b0;
            end
        end
        always_ff @(posedge clk) begin
            if (set_en && set_idx == IDX_W'(g)) begin
                tag_q[g] <= set_tag;
            end
        end
    end

    assign hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);

    assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> !valid_q[$past(clr_idx)]);
    assert_install_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> valid_q[$past(set_idx)]);
endmodule

// File: rtl/dcm_data_store.sv
module dcm_data_store #(
    parameter int LINES  = 16,
    parameter int BEATS  = 4,
    parameter int BEAT_W = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int BI_W  = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BI_W-1:0]   wr_beat,
    input  logic [BEAT_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [BI_W-1:0]   rd_beat,
    output logic [BEAT_W-1:0] rd_data
);
    logic [BEAT_W-1:0] mem_q [LINES*BEATS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[{wr_idx, wr_beat}] <= wr_data;
        end
    end

    assign rd_data = mem_q[{rd_idx, rd_beat}];
endmodule

// File: rtl/dcm_beat_ctr.sv
module dcm_beat_ctr #(
    parameter int BEATS = 4,
    localparam int BI_W = $clog2(BEATS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            adv,
    output logic [BI_W-1:0] cnt,
    output logic            last
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == BI_W'(BEATS - 1));
endmodule

// File: rtl/dcache_maint_ctrl.sv
module dcache_maint_ctrl
    import dcm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINES      = 16,
    parameter int LINE_BYTES = 16,
    parameter int BEAT_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [ADDR_W-1:0] op_addr,
    output logic              op_busy,
    output logic              op_done,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_done,
    output logic [BEAT_W-1:0] ld_data,
    output logic              ld_err,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_ack,
    input  logic              fill_err,
    input  logic [BEAT_W-1:0] fill_data
);
    localparam int BEATS    = LINE_BYTES * 8 / BEAT_W;
    localparam int BI_W     = $clog2(BEATS);
    localparam int OFF_W    = $clog2(LINE_BYTES);
    localparam int IDX_W    = $clog2(LINES);
    localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
    localparam int BYTE_OFF = $clog2(BEAT_W / 8);

    state_e            state_q, state_d;
    kind_e             kind_q, kind_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              err_q, err_d;

    logic              hit, clr_en, set_en, wr_en;
    logic              beat_clr, beat_adv, beat_last;
    logic [BI_W-1:0]   beat_cnt;
    logic [BEAT_W-1:0] rd_data;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic              op_ok;
    logic              unused_low;

    assign idx        = addr_q[OFF_W +: IDX_W];
    assign tag        = addr_q[ADDR_W-1 -: TAG_W];
    assign unused_low = ^addr_q[BYTE_OFF-1:0];

    always_comb begin
        unique case (op_code)
            OP_TOUCH, OP_TOUCH_ST, OP_INVAL, OP_BARRIER: op_ok = op_valid;
            default:                                    op_ok = 1'b0;
        endcase
    end

    dcm_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .rd_idx(idx), .rd_tag(tag), .hit(hit),
        .clr_en(clr_en), .clr_idx(idx),
        .set_en(set_en), .set_idx(idx), .set_tag(tag)
    );

    dcm_data_store #(.LINES(LINES), .BEATS(BEATS), .BEAT_W(BEAT_W)) u_data (
        .clk(clk), .wr_en(wr_en), .wr_idx(idx), .wr_beat(beat_cnt),
        .wr_data(fill_data), .rd_idx(idx),
        .rd_beat(addr_q[BYTE_OFF +: BI_W]), .rd_data(rd_data)
    );

    dcm_beat_ctr #(.BEATS(BEATS)) u_beat (
        .clk(clk), .rst_n(rst_n), .clr(beat_clr), .adv(beat_adv),
        .cnt(beat_cnt), .last(beat_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            kind_q  <= K_TOUCH;
            addr_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            addr_q  <= addr_d;
            err_q   <= err_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        kind_d   = kind_q;
        addr_d   = addr_q;
        err_d    = err_q;
        clr_en   = 1'b0;
        set_en   = 1'b0;
        wr_en    = 1'b0;
        beat_clr = 1'b0;
        beat_adv = 1'b0;
        fill_req = 1'b0;
        op_done  = 1'b0;
        ld_done  = 1'b0;
        ld_err   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                beat_clr = 1'b1;
                err_d    = 1'b0;
                if (op_ok) begin
                    addr_d  = op_addr;
                    state_d = S_LOOKUP;
                    unique case (op_code)
                        OP_INVAL:   kind_d = K_INVAL;
                        OP_BARRIER: kind_d = K_BARRIER;
                        default:    kind_d = K_TOUCH;
                    endcase
                end else if (ld_valid) begin
                    addr_d  = ld_addr;
                    kind_d  = K_LOAD;
                    state_d = S_LOOKUP;
                end
            end
            S_LOOKUP: begin
                unique case (kind_q)
                    K_INVAL: begin
                        clr_en  = hit;
                        state_d = S_DONE;
                    end
                    K_BARRIER: begin
                        // one access at a time: nothing is outstanding here
                        state_d = S_DONE;
                    end
                    default: begin
                        if (hit) begin
                            state_d = S_DONE;
                        end else begin
                            clr_en  = 1'b1;
                            state_d = S_FILL;
                        end
                    end
                endcase
            end
            S_FILL: begin
                fill_req = 1'b1;
                if (fill_ack) begin
                    if (fill_err) begin
                        err_d   = 1'b1;
                        state_d = S_DONE;
                    end else begin
                        wr_en    = 1'b1;
                        beat_adv = 1'b1;
                        if (beat_last) begin
                            set_en  = 1'b1;
                            state_d = S_DONE;
                        end
                    end
                end
            end
            S_DONE: begin
                op_done = (kind_q != K_LOAD);
                ld_done = (kind_q == K_LOAD);
                ld_err  = (kind_q == K_LOAD) && err_q;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign op_busy   = (state_q != S_IDLE);
    assign ld_data   = (ld_done && !err_q) ? rd_data : '0;
    assign fill_addr = {addr_q[ADDR_W-1:OFF_W], beat_cnt, {BYTE_OFF{1'b0}}};

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done || ld_done) |=> !(op_done || ld_done));
    assert_busy_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done || ld_done) |-> op_busy);
    assert_fill_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_ack) |=> (fill_req && $stable(fill_addr)));
    assert_touch_no_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_err |-> (ld_done && !op_done));
    assert_barrier_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOOKUP) |-> !fill_req);
    assert_single_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({op_done, ld_done}) <= 1);
endmodule

// File: tb/dcache_maint_ctrl_bench.sv
module dcache_maint_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [31:0] op_addr = '0;
    logic        op_busy, op_done;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_addr = '0;
    logic        ld_done, ld_err;
    logic [31:0] ld_data;
    logic        fill_req;
    logic [31:0] fill_addr;
    logic        fill_ack = 1'b0;
    logic        fill_err = 1'b0;
    logic [31:0] fill_data = '0;

    int checks = 0;
    int failures = 0;
    int beats_seen = 0;
    logic [2:0] err_beat = 3'd4;

    always #4 clk = ~clk;

    dcache_maint_ctrl u_dcache_maint_ctrl (
        .clk(clk), .rst_n(rst_n),
        .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr),
        .op_busy(op_busy), .op_done(op_done),
        .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_done(ld_done), .ld_data(ld_data), .ld_err(ld_err),
        .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_ack(fill_ack), .fill_err(fill_err), .fill_data(fill_data)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'h5A5A_F00F;
    endfunction

    // Bus model: acknowledges every requested beat one half cycle later
    always @(negedge clk) begin
        fill_ack  <= fill_req;
        fill_err  <= fill_req && (err_beat < 3'd4) && (fill_addr[3:2] == err_beat[1:0]);
        fill_data <= mem_word(fill_addr);
    end

    always @(posedge clk) begin
        if (fill_req && fill_ack) beats_seen <= beats_seen + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    localparam logic [2:0] LD = 3'd7;
    localparam logic [2:0] NO = 3'd4;
    // {op, addr, error beat, latency, beats, ld_err}
    localparam logic [45:0] VEC [16] = '{
        {LD,    32'h1000_0040, NO,   4'd6, 3'd4, 1'b0}, // R4 R6 R11 load miss
        {LD,    32'h1000_0044, NO,   4'd2, 3'd0, 1'b0}, // R9 load hit
        {3'd1,  32'h2000_0080, 3'd1, 4'd4, 3'd2, 1'b0}, // R5 touch error beat 1
        {LD,    32'h2000_0084, NO,   4'd6, 3'd4, 1'b0}, // R5 line left invalid
        {3'd2,  32'h3000_0100, NO,   4'd6, 3'd4, 1'b0}, // R4 touch-for-store miss
        {3'd1,  32'h3000_0104, NO,   4'd2, 3'd0, 1'b0}, // R3 R6 touch hit
        {3'd3,  32'h3000_0100, NO,   4'd2, 3'd0, 1'b0}, // R7 invalidate hit
        {LD,    32'h3000_0108, NO,   4'd6, 3'd4, 1'b0}, // R7 line was cleared
        {3'd3,  32'h4000_0200, NO,   4'd2, 3'd0, 1'b0}, // R7 invalidate miss
        {LD,    32'h3000_010C, NO,   4'd2, 3'd0, 1'b0}, // R7 miss had no effect
        {3'd4,  32'h0000_0000, NO,   4'd2, 3'd0, 1'b0}, // R8 barrier
        {LD,    32'h5000_0340, 3'd3, 4'd6, 3'd4, 1'b1}, // R9 load bus error
        {LD,    32'h5000_0340, NO,   4'd6, 3'd4, 1'b0}, // R6 errored load not installed
        {3'd1,  32'h1000_0040, NO,   4'd6, 3'd4, 1'b0}, // R11 replaced by same index
        {LD,    32'h5000_0340, NO,   4'd6, 3'd4, 1'b0}, // R11 evicted again
        {3'd2,  32'h2000_0080, NO,   4'd2, 3'd0, 1'b0}  // R3 touch-for-store hit
    };

    task automatic run(input logic [2:0] op, input logic [31:0] a, input logic [2:0] eb,
                       input int lat, input int nbeats, input logic exp_err);
        int n;
        int start;
        bit is_ld;
        is_ld = (op == LD);
        @(negedge clk);
        err_beat = eb;
        start = beats_seen;
        if (is_ld) begin
            ld_valid = 1'b1; ld_addr = a;
        end else begin
            op_valid = 1'b1; op_code = op; op_addr = a;
        end
        @(negedge clk);
        ld_valid = 1'b0; op_valid = 1'b0; op_code = 3'd0;
        check(op_busy == 1'b1, "R10", "busy after accept", op_busy, 1);
        n = 1;
        while (!(op_done || ld_done) && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(n == lat, is_ld ? "R9" : "R3", "done latency", n, lat);
        check((beats_seen - start) == nbeats, "R4", "fill beats", beats_seen - start, nbeats);
        check(is_ld ? ld_done : op_done, "R10", "done on matching port", 0, 1);
        check(ld_err == exp_err, is_ld ? "R9" : "R5", "ld_err", ld_err, exp_err);
        if (is_ld && !exp_err)
            check(ld_data == mem_word(a), "R9", "ld_data", ld_data, mem_word(a));
        @(negedge clk);
        check(!op_done && !ld_done && !op_busy, "R10", "pulse and busy dropped",
              {op_done, ld_done, op_busy}, 0);
        err_beat = NO;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!op_busy && !op_done && !ld_done && !fill_req, "R1", "reset outputs",
              {op_busy, op_done, ld_done, fill_req}, 0);

        for (int i = 0; i < 16; i++) begin
            run(VEC[i][45:43], VEC[i][42:11], VEC[i][10:8],
                int'(VEC[i][7:4]), int'(VEC[i][3:1]), VEC[i][0]);
        end

        // R2: code 000 and unused codes are not accepted
        for (int c = 0; c < 8; c += 5) begin
            @(negedge clk);
            op_valid = 1'b1; op_code = 3'(c); op_addr = 32'h1000_0040;
            @(negedge clk);
            op_valid = 1'b0; op_code = 3'd0;
            check(!op_busy, "R2", "unaccepted code", op_busy, 0);
        end
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd7;
        @(negedge clk);
        op_valid = 1'b0; op_code = 3'd0;
        check(!op_busy, "R2", "code 111 ignored", op_busy, 0);

        // R1: a later reset invalidates installed lines
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(!op_busy && !fill_req, "R1", "idle after reset", {op_busy, fill_req}, 0);
        run(LD, 32'h5000_0340, NO, 6, 4, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule